// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock into the periodic enables that pace one serial channel. A programmable divisor with a 16-bit whole part and a 4-bit sixteenths part sets the spacing of a single-cycle sampling tick. A second single-cycle tick marks each bit period. It fires on every 16th, 8th or 4th sampling tick, according to the selected oversampling mode. An optional divide-by-four stage ahead of the divisor cuts every rate to a quarter.

Configuration is captured on a load strobe. The two divisor bytes are always taken. The fraction and mode byte is taken only while the extended-feature enable is high. The divide-by-four select is taken with each load. Every load, and every reset, restarts all counters from zero, so the next tick arrives after one full period and no shortened tick is emitted. The fraction is spread over groups of 16 sampling periods. F of those 16 periods are each one prescaled reference cycle longer, and the spacing of the lengthened periods follows a running 4-bit phase sum.

Top module: `frac_baud_gen`

## Requirements
- R1: The whole divisor N is `{div_hi, div_lo}` as a 16-bit value. With no fraction and no prescaling, `samp_tick` is high for one clock every N clocks.
- R2: With fraction F = `frac_cfg[3:0]`, sampling period k (k = 0 after a restart) lasts N + floor((k+1)F/16) - floor(kF/16) prescaled cycles. Over any 16 consecutive periods, F of them are lengthened by one.
- R3: After reset the divisor is 1, the fraction is 0, the mode is 16X and the prescaler divides by 1. `samp_tick` is high on every clock from the first edge after reset is released, and `bit_tick` is high on every 16th of those ticks.
- R4: When `pre_div4` is captured high, every period is four times as many clocks. Each sampling tick follows an edge at which the internal prescale enable was active.
- R5: The mode field `frac_cfg[5:4]` selects the bits per bit period: 00 gives 16 sampling ticks, 01 gives 8, and 10 or 11 give 4.
- R6: The fraction and the mode are captured on `cfg_load` only while `ext_en` is high. With `ext_en` low, the previously captured fraction and mode stay in force.
- R7: A whole divisor of 0 behaves exactly like a divisor of 1.
- R8: At the edge that captures `cfg_load`, both ticks go low and all counters restart. The first sampling tick then comes exactly P0 × prescale clocks after that edge.
- R9: `bit_tick` is high only together with `samp_tick`, on the sampling ticks numbered M, 2M, 3M and so on after a restart, where M is the mode ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for configuration; restarts all counters |
| ext_en | input | 1 | Extended-feature enable; allows the fraction and mode byte to be captured |
| div_lo | input | 8 | Low byte of the whole divisor |
| div_hi | input | 8 | High byte of the whole divisor |
| frac_cfg | input | 8 | [3:0] fraction in sixteenths, [5:4] oversampling mode, [7:6] unused |
| pre_div4 | input | 1 | 1 selects a divide-by-four stage before the divisor |
| samp_tick | output | 1 | Single-cycle sampling-rate tick |
| bit_tick | output | 1 | Single-cycle bit-rate tick |

## Verification
The assertions assume that configuration changes only through `cfg_load`, so the counter bounds and the phase sum always refer to one captured divisor. They also assume that the clock runs continuously after reset. The stimulus drives new values only together with a load strobe. It holds the strobe for exactly one clock and then lets the generator run for a fixed number of sampling ticks. Each tick is compared against a period schedule computed from the divisor arithmetic, and every clock in between is checked for silence.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DIV_W  = 16;
  localparam int FRAC_W = 4;
  localparam int MCNT_W = 5;

  typedef enum logic [1:0] {OS_16X = 2'd0, OS_8X = 2'd1, OS_4X = 2'd2} os_mode_e;

  // whole divisor with zero mapped to one
  function automatic logic [DIV_W:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? {{DIV_W{1'b0}}, 1'b1} : {1'b0, d};
  endfunction

  // carry out of phase + fraction decides whether this period is lengthened
  function automatic logic stretch_bit(input logic [FRAC_W-1:0] ph, input logic [FRAC_W-1:0] f);
    logic [FRAC_W:0] s;
    s = {1'b0, ph} + {1'b0, f};
    return s[FRAC_W];
  endfunction

  function automatic os_mode_e decode_mode(input logic [1:0] bits);
    case (bits)
      2'b00:   return OS_16X;
      2'b01:   return OS_8X;
      default: return OS_4X;
    endcase
  endfunction

  function automatic logic [MCNT_W-1:0] os_ratio(input os_mode_e m);
    case (m)
      OS_16X:  return 5'd16;
      OS_8X:   return 5'd8;
      default: return 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int PRE_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic div_sel,
  output logic pre_en
);
  localparam int PW = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (restart)       pcnt <= '0;
    else if (pcnt == LAST)  pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end

  assign pre_en = div_sel ? (pcnt == LAST) : 1'b1;
endmodule

// File: rtl/fbg_div_core.sv
module fbg_div_core
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_en,
  input  logic [DIV_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac,
  output logic              wrap,
  output logic              tick,
  output logic [DIV_W:0]    cnt_o,
  output logic [DIV_W:0]    period_o
);
  logic [DIV_W:0]  cnt;
  logic [FRAC_W-1:0] phase;
  logic [DIV_W:0]  period;

  assign period   = eff_div(int_div) + {{DIV_W{1'b0}}, stretch_bit(phase, frac)};
  assign wrap     = pre_en && (cnt == period - 1'b1) && !restart;
  assign cnt_o    = cnt;
  assign period_o = period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
      tick  <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        cnt   <= '0;
        phase <= phase + frac;
      end else if (pre_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              samp_wrap,
  input  logic [MCNT_W-1:0] ratio,
  output logic              bit_tick,
  output logic [MCNT_W-1:0] mcnt_o
);
  logic [MCNT_W-1:0] mcnt;
  logic              last;

  assign last   = (mcnt == ratio - 1'b1);
  assign mcnt_o = mcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt     <= '0;
      bit_tick <= 1'b0;
    end else if (restart) begin
      mcnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= samp_wrap && last;
      if (samp_wrap) mcnt <= last ? '0 : mcnt + 1'b1;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       ext_en,
  input  logic [7:0] div_lo,
  input  logic [7:0] div_hi,
  input  logic [7:0] frac_cfg,
  input  logic       pre_div4,
  output logic       samp_tick,
  output logic       bit_tick
);
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  os_mode_e          mode_q;
  logic              p4_q;

  logic              pre_en;
  logic              samp_wrap;
  logic [DIV_W:0]    cnt_w;
  logic [DIV_W:0]    period_w;
  logic [MCNT_W-1:0] mcnt_w;
  logic [MCNT_W-1:0] ratio_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(1);
      frac_q <= '0;
      mode_q <= OS_16X;
      p4_q   <= 1'b0;
    end else if (cfg_load) begin
      div_q <= {div_hi, div_lo};
      p4_q  <= pre_div4;
      if (ext_en) begin
        frac_q <= frac_cfg[FRAC_W-1:0];
        mode_q <= decode_mode(frac_cfg[5:4]);
      end
    end
  end

  assign ratio_w = os_ratio(mode_q);

  fbg_prescaler #(.PRE_RATIO(4)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .div_sel(p4_q), .pre_en(pre_en)
  );

  fbg_div_core u_core (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .pre_en(pre_en),
    .int_div(div_q), .frac(frac_q), .wrap(samp_wrap), .tick(samp_tick),
    .cnt_o(cnt_w), .period_o(period_w)
  );

  fbg_bit_div u_bit (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .samp_wrap(samp_wrap),
    .ratio(ratio_w), .bit_tick(bit_tick), .mcnt_o(mcnt_w)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
  import fbg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              pre_en,
  input logic              samp_tick,
  input logic              bit_tick,
  input logic [DIV_W:0]    cnt_w,
  input logic [DIV_W:0]    period_w,
  input logic [MCNT_W-1:0] mcnt_w,
  input logic [MCNT_W-1:0] ratio_w
);
  assert_bit_with_samp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);

  assert_no_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!samp_tick && !bit_tick));

  assert_tick_on_prescale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && !$past(cfg_load)) |-> $past(pre_en));

  assert_count_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_w != '0) && (cnt_w < period_w));

  assert_mode_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_w < ratio_w);
endmodule

bind frac_baud_gen fbg_checker u_fbg_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .pre_en(pre_en),
  .samp_tick(samp_tick), .bit_tick(bit_tick), .cnt_w(cnt_w),
  .period_w(period_w), .mcnt_w(mcnt_w), .ratio_w(ratio_w)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, ext_en = 1'b0, pre_div4 = 1'b0;
  logic [7:0] div_lo = 8'h0, div_hi = 8'h0, frac_cfg = 8'h0;
  logic samp_tick, bit_tick;

  int tests = 0, fails = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cycles++;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .ext_en(ext_en),
    .div_lo(div_lo), .div_hi(div_hi), .frac_cfg(frac_cfg),
    .pre_div4(pre_div4), .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  // number of extra cycles in period j for fraction f
  function automatic int extra(input int j, input int f);
    return ((j + 1) * f) / 16 - (j * f) / 16;
  endfunction

  // Follow the expected schedule from the restart edge (t = 0) for nt ticks.
  task automatic follow(input string req, input int ndiv, input int f,
                        input int presc, input int ratio, input int nt);
    int k = 0, t = 0, next_t, bad = 0;
    int eff;
    bit es, eb;
    eff = (ndiv == 0) ? 1 : ndiv;
    next_t = presc * (eff + extra(0, f));
    while (k < nt) begin
      @(negedge clk); t++;
      es = (t == next_t);
      eb = es && (((k + 1) % ratio) == 0);
      if ((samp_tick !== es || bit_tick !== eb) && bad == 0) begin
        $display("FAIL %s: div=%0d f=%0d presc=%0d ratio=%0d t=%0d got samp=%b bit=%b expected samp=%b bit=%b",
                 req, ndiv, f, presc, ratio, t, samp_tick, bit_tick, es, eb);
        bad = 1;
      end
      if (es) begin
        k++;
        next_t += presc * (eff + extra(k, f));
      end
    end
    tests++;
    if (bad) fails++;
  endtask

  task automatic load(input int ndiv, input int fc, input bit en, input bit p4);
    @(negedge clk);
    div_lo = ndiv[7:0]; div_hi = ndiv[15:8]; frac_cfg = fc[7:0];
    ext_en = en; pre_div4 = p4; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    // samples after the load edge must be idle (R8)
    tests++;
    if (samp_tick !== 1'b0 || bit_tick !== 1'b0) begin
      fails++;
      $display("FAIL R8: ticks after load got samp=%b bit=%b expected 0 0", samp_tick, bit_tick);
    end
  endtask

  task automatic load_run(input string req, input int ndiv, input int fc, input bit en,
                          input bit p4, input int f_exp, input int ratio_exp, input int nt);
    // load() consumes the negedge at t = 0; follow() starts counting from there
    load(ndiv, fc, en, p4);
    follow(req, ndiv, f_exp, p4 ? 4 : 1, ratio_exp, nt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                        // next posedge is t = 1
    follow("R3 reset defaults", 1, 0, 1, 16, 40);

    // R1: whole divisor from both bytes, including the high byte
    load_run("R1 div=5", 5, 8'h00, 1, 0, 0, 16, 20);
    load_run("R1 div=0x0102", 16'h0102, 8'h00, 1, 0, 0, 16, 3);

    // R2/R4/R7: sweep divisor, every fraction, both prescaler settings
    foreach (int_a[i]) ;
    for (int d = 0; d < 4; d++) begin
      for (int f = 0; f < 16; f++) begin
        for (int p = 0; p < 2; p++) begin
          int nd;
          nd = (d == 3) ? 3 : d;
          load_run((d == 0) ? "R7 zero divisor" : (p ? "R4 prescale" : "R2 fraction"),
                   nd, f, 1, p[0], f, 16, 18);
        end
      end
    end

    // R5: mode field decoding
    load_run("R5 mode 00", 2, 8'h05, 1, 0, 5, 16, 34);
    load_run("R5 mode 01", 2, 8'h15, 1, 0, 5, 8, 34);
    load_run("R5 mode 10", 2, 8'h25, 1, 0, 5, 4, 34);
    load_run("R5 mode 11", 2, 8'h35, 1, 1, 5, 4, 34);

    // R6: fraction/mode ignored while the extended enable is low
    load_run("R6 set", 3, 8'h17, 1, 0, 7, 8, 20);
    load_run("R6 gated", 3, 8'h00, 0, 0, 7, 8, 20);
    load_run("R6 gated again", 1, 8'h2F, 0, 0, 7, 8, 20);
    load_run("R6 ungated", 1, 8'h2F, 1, 0, 15, 4, 20);

    // R8/R9: reload in the middle of a period restarts cleanly
    load(4, 8'h13, 1, 1);
    repeat (7) @(negedge clk);
    load_run("R8 mid-period reload", 2, 8'h13, 1, 0, 3, 8, 20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int int_a[1];

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule